// File: doc/BRIEF.md
# Sixteen-Function Bit-Manipulation ALU

This block is a purely combinational 16-bit arithmetic and logic unit. It takes two operand words, `a` and `b`, and a 4-bit function select. It returns one result word. The functions cover the usual bitwise logic and modular arithmetic. There is also a byte merge that pastes the low byte of `b` above the low byte of `a`, which is useful for building wide constants from 8-bit immediates. The remaining functions are signed comparisons that return 0 or 1, single-place shifts, and four single-bit operations. Those four set, clear, test or generate the bit whose index is held in the low four bits of `b`.

The block sits inside an execution stage and has no clock of its own. A new result appears after combinational delay whenever any input changes. It reports no flags and no carry.

Top module: `alu16_bitops`

## Requirements
- R1: Function codes 0x0, 0x1, 0x2 and 0x3 return `b`, `a & b`, `a | b` and `a ^ b` respectively.
- R2: Code 0x4 returns `a + b` and code 0x5 returns `a - b`, both wrapped modulo 2^16.
- R3: Code 0x6 returns the low 16 bits of the product `a * b`.
- R4: Code 0x7 returns `b[7:0]` in bits 15:8 and `a[7:0]` in bits 7:0.
- R5: Code 0x8 returns 1 when `a < b` and code 0x9 returns 1 when `a <= b`, with both operands read as signed two's complement; otherwise each returns 0, and bits 15:1 of a comparison result are always 0.
- R6: Code 0xA returns `a` shifted right by one with a zero in bit 15, and code 0xB returns `a` shifted left by one with a zero in bit 0; `b` has no effect on either.
- R7: Code 0xC returns `a` with bit `b[3:0]` forced to 1, and code 0xD returns `a` with that bit forced to 0.
- R8: Code 0xE returns `a` with every bit except bit `b[3:0]` cleared.
- R9: Code 0xF returns a word with only bit `b[3:0]` set; for codes 0xC to 0xF, bits 15:4 of `b` have no effect.
- R10: The result follows input changes with no clock edge and holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand, also the source word for shifts and bit operations |
| b | input | 16 | Second operand; bits 3:0 give the bit index for codes 0xC to 0xF |
| fn | input | 4 | Function select |
| result | output | 16 | Computed result word |

## Verification
The assertions watch the result's shape whenever the inputs are defined. A comparison leaves bits 15:1 at zero. A right shift clears the top bit and a left shift clears the bottom bit. A set-bit result contains every bit of `a`, and a clear-bit result contains none that `a` lacks. A bit test has at most one bit set and only where `a` has one, and a generated mask has exactly one bit set. The exact values need the bench's scenarios. These include wraparound of add, subtract and multiply, and the signed ordering across the 0x7FFF/0x8000 boundary. Also covered are equal operands for both comparisons, bit indices 0 and 15 with junk in `b[15:4]`, and the proof that `b` does not change a shift.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [3:0] {
    FN_PASS  = 4'h0,
    FN_AND   = 4'h1,
    FN_OR    = 4'h2,
    FN_XOR   = 4'h3,
    FN_ADD   = 4'h4,
    FN_SUB   = 4'h5,
    FN_MUL   = 4'h6,
    FN_MERGE = 4'h7,
    FN_LT    = 4'h8,
    FN_LE    = 4'h9,
    FN_SHR   = 4'hA,
    FN_SHL   = 4'hB,
    FN_SETB  = 4'hC,
    FN_CLRB  = 4'hD,
    FN_TSTB  = 4'hE,
    FN_GENB  = 4'hF
  } aluFn_t;

  // one-hot result strobes from decode to datapath
  typedef struct packed {
    logic passB;
    logic andOp;
    logic orOp;
    logic xorOp;
    logic addOp;
    logic subOp;
    logic mulOp;
    logic mergeOp;
    logic ltOp;
    logic leOp;
    logic shrOp;
    logic shlOp;
    logic setOp;
    logic clrOp;
    logic tstOp;
    logic genOp;
  } aluStrobes_t;

endpackage

// File: rtl/alu16_ctrl.sv
module alu16_ctrl
  import alu16_pkg::*;
(
  input  logic [3:0]  fn,
  output aluStrobes_t strobes
);

  always_comb begin
    strobes = '0;
    unique case (fn)
      FN_PASS:  strobes.passB   = 1'b1;
      FN_AND:   strobes.andOp   = 1'b1;
      FN_OR:    strobes.orOp    = 1'b1;
      FN_XOR:   strobes.xorOp   = 1'b1;
      FN_ADD:   strobes.addOp   = 1'b1;
      FN_SUB:   strobes.subOp   = 1'b1;
      FN_MUL:   strobes.mulOp   = 1'b1;
      FN_MERGE: strobes.mergeOp = 1'b1;
      FN_LT:    strobes.ltOp    = 1'b1;
      FN_LE:    strobes.leOp    = 1'b1;
      FN_SHR:   strobes.shrOp   = 1'b1;
      FN_SHL:   strobes.shlOp   = 1'b1;
      FN_SETB:  strobes.setOp   = 1'b1;
      FN_CLRB:  strobes.clrOp   = 1'b1;
      FN_TSTB:  strobes.tstOp   = 1'b1;
      FN_GENB:  strobes.genOp   = 1'b1;
      default:  strobes = '0;
    endcase
  end

endmodule

// File: rtl/alu16_dp.sv
module alu16_dp
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result
);

  localparam int HALF = WIDTH / 2;
  localparam int IDXW = $clog2(WIDTH);
  localparam int MSB  = WIDTH - 1;

  logic [WIDTH-1:0] sumOut;
  logic [WIDTH-1:0] diffOut;
  logic [WIDTH-1:0] prodOut;
  logic [WIDTH-1:0] bitMask;
  logic [IDXW-1:0]  bitIdx;
  logic             lessThan;
  logic             isEqual;
  logic [WIDTH-1:0] ltWord;
  logic [WIDTH-1:0] leWord;

  assign sumOut  = a + b;
  // shared subtractor feeds both subtract and the signed compares
  assign diffOut = a + ~b + {{(WIDTH-1){1'b0}}, 1'b1};
  assign prodOut = a * b;

  assign bitIdx  = b[IDXW-1:0];
  assign bitMask = {{(WIDTH-1){1'b0}}, 1'b1} << bitIdx;

  // signs differ: negative operand is smaller; otherwise difference sign decides
  assign lessThan = (a[MSB] ^ b[MSB]) ? a[MSB] : diffOut[MSB];
  assign isEqual  = (a == b);
  assign ltWord   = {{(WIDTH-1){1'b0}}, lessThan};
  assign leWord   = {{(WIDTH-1){1'b0}}, lessThan | isEqual};

  always_comb begin
    result = ({WIDTH{strobes.passB}}   & b)
           | ({WIDTH{strobes.andOp}}   & (a & b))
           | ({WIDTH{strobes.orOp}}    & (a | b))
           | ({WIDTH{strobes.xorOp}}   & (a ^ b))
           | ({WIDTH{strobes.addOp}}   & sumOut)
           | ({WIDTH{strobes.subOp}}   & diffOut)
           | ({WIDTH{strobes.mulOp}}   & prodOut)
           | ({WIDTH{strobes.mergeOp}} & {b[HALF-1:0], a[HALF-1:0]})
           | ({WIDTH{strobes.ltOp}}    & ltWord)
           | ({WIDTH{strobes.leOp}}    & leWord)
           | ({WIDTH{strobes.shrOp}}   & {1'b0, a[MSB:1]})
           | ({WIDTH{strobes.shlOp}}   & {a[MSB-1:0], 1'b0})
           | ({WIDTH{strobes.setOp}}   & (a | bitMask))
           | ({WIDTH{strobes.clrOp}}   & (a & ~bitMask))
           | ({WIDTH{strobes.tstOp}}   & (a & bitMask))
           | ({WIDTH{strobes.genOp}}   & bitMask);
  end

endmodule

// File: rtl/alu16_bitops.sv
module alu16_bitops
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [3:0]       fn,
  output logic [WIDTH-1:0] result
);

  aluStrobes_t strobes;

  alu16_ctrl u_ctrl (
    .fn      (fn),
    .strobes (strobes)
  );

  alu16_dp #(.WIDTH(WIDTH)) u_dp (
    .a       (a),
    .b       (b),
    .strobes (strobes),
    .result  (result)
  );

endmodule

// File: rtl/alu16_bitops_chk.sv
module alu16_bitops_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [3:0]       fn,
  input logic [WIDTH-1:0] result
);

  always_comb begin
    if (!$isunknown({a, b, fn, result})) begin
      // R5
      cmp_range_chk: assert (!(fn == 4'h8 || fn == 4'h9) || result[WIDTH-1:1] == '0)
        else $error("compare result wider than one bit");
      // R6
      shr_fill_chk: assert (fn != 4'hA || result[WIDTH-1] == 1'b0)
        else $error("right shift top bit not zero");
      // R6
      shl_fill_chk: assert (fn != 4'hB || result[0] == 1'b0)
        else $error("left shift bottom bit not zero");
      // R7
      setb_keep_chk: assert (fn != 4'hC || (result & a) == a)
        else $error("set-bit lost a bit of a");
      // R7
      clrb_keep_chk: assert (fn != 4'hD || (result | a) == a)
        else $error("clear-bit added a bit");
      // R8
      tstb_mask_chk: assert (fn != 4'hE || ($countones(result) <= 1 && (result & ~a) == '0))
        else $error("bit test result malformed");
      // R9
      genb_onehot_chk: assert (fn != 4'hF || $countones(result) == 1)
        else $error("generated mask not one-hot");
    end
  end

endmodule

bind alu16_bitops alu16_bitops_chk #(.WIDTH(WIDTH)) u_chk (
  .a      (a),
  .b      (b),
  .fn     (fn),
  .result (result)
);

// File: tb/sim_alu16_bitops.sv
module sim_alu16_bitops;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] a;
  logic [15:0] b;
  logic [3:0]  fn;
  logic [15:0] result;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  alu16_bitops u0 (
    .a      (a),
    .b      (b),
    .fn     (fn),
    .result (result)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [15:0] model(input logic [15:0] x, input logic [15:0] y,
                                        input logic [3:0] f);
    logic [15:0] m;
    logic [31:0] p;
    m = 16'h0001 << y[3:0];
    p = x * y;
    case (f)
      4'h0: return y;
      4'h1: return x & y;
      4'h2: return x | y;
      4'h3: return x ^ y;
      4'h4: return 16'(x + y);
      4'h5: return 16'(x - y);
      4'h6: return p[15:0];
      4'h7: return {y[7:0], x[7:0]};
      4'h8: return ($signed(x) < $signed(y)) ? 16'd1 : 16'd0;
      4'h9: return ($signed(x) <= $signed(y)) ? 16'd1 : 16'd0;
      4'hA: return x >> 1;
      4'hB: return x << 1;
      4'hC: return x | m;
      4'hD: return x & ~m;
      4'hE: return x & m;
      default: return m;
    endcase
  endfunction

  task automatic apply(input logic [3:0] f, input logic [15:0] x, input logic [15:0] y);
    @(negedge clk);
    fn = f; a = x; b = y;
    #1;
  endtask

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s fn=%h a=%h b=%h: actual %h expected %h", req, fn, a, b, result, exp);
    end
  endtask

  task automatic run(input string req, input logic [3:0] f, input logic [15:0] x,
                     input logic [15:0] y, input logic [15:0] exp);
    apply(f, x, y);
    check(req, exp);
  endtask

  task automatic test_idle;
    run("R1", 4'h0, 16'h0000, 16'h0000, 16'h0000);
  endtask

  task automatic test_logic_r1;
    run("R1", 4'h0, 16'h1234, 16'hBEEF, 16'hBEEF);
    run("R1", 4'h1, 16'hF0F0, 16'h3C3C, 16'h3030);
    run("R1", 4'h2, 16'hF0F0, 16'h3C3C, 16'hFCFC);
    run("R1", 4'h3, 16'hF0F0, 16'h3C3C, 16'hCCCC);
  endtask

  task automatic test_arith_r2;
    run("R2", 4'h4, 16'hFFFF, 16'h0002, 16'h0001);
    run("R2", 4'h4, 16'h7FFF, 16'h0001, 16'h8000);
    run("R2", 4'h5, 16'h0000, 16'h0001, 16'hFFFF);
    run("R2", 4'h5, 16'h1000, 16'h0234, 16'h0DCC);
  endtask

  task automatic test_mul_r3;
    run("R3", 4'h6, 16'h0100, 16'h0100, 16'h0000);
    run("R3", 4'h6, 16'h00FF, 16'h00FF, 16'hFE01);
    run("R3", 4'h6, 16'hFFFF, 16'h0003, 16'hFFFD);
  endtask

  task automatic test_merge_r4;
    run("R4", 4'h7, 16'hAB12, 16'hCD34, 16'h3412);
    run("R4", 4'h7, 16'h00FF, 16'hFF80, 16'h80FF);
  endtask

  task automatic test_compare_r5;
    run("R5", 4'h8, 16'h0005, 16'h0005, 16'h0000);
    run("R5", 4'h9, 16'h0005, 16'h0005, 16'h0001);
    run("R5", 4'h8, 16'h8000, 16'h7FFF, 16'h0001);
    run("R5", 4'h9, 16'h7FFF, 16'h8000, 16'h0000);
    run("R5", 4'h8, 16'hFFFF, 16'h0000, 16'h0001);
    run("R5", 4'h9, 16'h8000, 16'h8000, 16'h0001);
    run("R5", 4'h8, 16'h0003, 16'h0002, 16'h0000);
  endtask

  task automatic test_shift_r6;
    run("R6", 4'hA, 16'h8001, 16'h0000, 16'h4000);
    run("R6", 4'hA, 16'h8001, 16'hFFFF, 16'h4000);
    run("R6", 4'hB, 16'h8001, 16'h0000, 16'h0002);
    run("R6", 4'hB, 16'h8001, 16'h1234, 16'h0002);
  endtask

  task automatic test_bits_r7_r8_r9;
    run("R7", 4'hC, 16'h0000, 16'h0000, 16'h0001);
    run("R7", 4'hC, 16'h0000, 16'hFFFF, 16'h8000);
    run("R7", 4'hD, 16'hFFFF, 16'h0000, 16'hFFFE);
    run("R7", 4'hD, 16'hFFFF, 16'h000F, 16'h7FFF);
    run("R8", 4'hE, 16'hFFFF, 16'hABC0, 16'h0001);
    run("R8", 4'hE, 16'h7FFF, 16'h000F, 16'h0000);
    run("R8", 4'hE, 16'h8000, 16'h123F, 16'h8000);
    run("R9", 4'hF, 16'h5555, 16'hFFF0, 16'h0001);
    run("R9", 4'hF, 16'h0000, 16'h000F, 16'h8000);
    run("R9", 4'hF, 16'hFFFF, 16'h0A07, 16'h0080);
  endtask

  task automatic test_nostate_r10;
    apply(4'h4, 16'h0001, 16'h0001);
    fn = 4'h3; a = 16'h00FF; b = 16'h0F0F;
    #1;
    check("R10", 16'h0FF0);
  endtask

  task automatic test_random_all;
    for (int k = 0; k < 400; k++) begin
      logic [3:0]  f;
      logic [15:0] x;
      logic [15:0] y;
      string tag;
      f = 4'(k % 16);
      x = 16'($urandom);
      y = 16'($urandom);
      case (f)
        4'h0, 4'h1, 4'h2, 4'h3: tag = "R1";
        4'h4, 4'h5: tag = "R2";
        4'h6: tag = "R3";
        4'h7: tag = "R4";
        4'h8, 4'h9: tag = "R5";
        4'hA, 4'hB: tag = "R6";
        4'hC, 4'hD: tag = "R7";
        4'hE: tag = "R8";
        default: tag = "R9";
      endcase
      run(tag, f, x, y, model(x, y, f));
    end
  endtask

  initial begin
    a = '0; b = '0; fn = '0;
    void'($urandom(32'h1D5));
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    test_idle();
    test_logic_r1();
    test_arith_r2();
    test_mul_r3();
    test_merge_r4();
    test_compare_r5();
    test_shift_r6();
    test_bits_r7_r8_r9();
    test_nostate_r10();
    test_random_all();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule